// File: doc/BRIEF.md
# Early-Terminating Serial Multiplier

This block multiplies two 32-bit operands by shift-and-add, one bit of the iterated operand per clock. A one-cycle `start_i` pulse while the block is idle captures the operands and the operation code. One partial product is added per cycle. When the product is ready, the block raises `done_o` for a single cycle. During that cycle `result_o` holds either the low or the high 32 bits of the 64-bit product, depending on the operation.

For the low-half operation the loop stops as soon as no set bits remain in the shifted iterated operand. The latency then follows the bit length of that operand and is not a fixed 32. When the operation commutes and both operands share one signedness, the block puts the smaller unsigned operand in the iterated position at capture time. This makes an early exit more likely. The three high-half operations always run all 32 steps. For a signed iterated operand, the final step subtracts its partial product instead of adding it.

Top module: `smul_top`

## Requirements
- R1: With `op_i` = 2'b00, `result_o` during the `done_o` cycle equals bits 31:0 of `a_i * b_i`.
- R2: With `op_i` = 2'b01 (both operands signed), 2'b10 (`a_i` signed, `b_i` unsigned) or 2'b11 (both unsigned), `result_o` during the `done_o` cycle equals bits 63:32 of the 64-bit product under that signedness.
- R3: With `op_i` = 2'b00, `done_o` rises N rising edges after the edge that captured `start_i`. N is the bit length of min(`a_i`, `b_i`) taken as unsigned values, and N is 1 when that minimum is zero.
- R4: With `op_i` = 2'b01, 2'b10 or 2'b11, `done_o` rises exactly 32 edges after the capturing edge, whatever the operand values.
- R5: For `op_i` = 2'b00 and 2'b11, swapping `a_i` and `b_i` changes neither the result nor the latency.
- R6: `done_o` is high for exactly one cycle per accepted start. A new start is accepted on the cycle after that.
- R7: A `start_i` pulse that arrives while an operation is in progress is ignored. It changes neither the running result nor its latency, and it produces no further `done_o`.
- R8: After reset, `done_o` is low and stays low until a start is accepted.
- R9: With `op_i` = 2'b00, a zero operand finishes with the minimum latency of 1 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| op_i | input | 2 | 00 low half, 01 high signed×signed, 10 high signed×unsigned, 11 high unsigned×unsigned |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Selected half of the product, valid while done_o is high |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach is a start that lands in the middle of a 32-step high-half run. A second case is an iterated operand whose bit length differs from the other operand's, so that the swap decision alone sets the latency. The bench issues a signed high-half operation and then pulses start with different operands a few cycles into the run. It checks that the first result, its latency and the absence of any second strobe are all unaffected. For the swap, the bench runs each low-half operand pair in both orders and compares the exact edge count of each run against the bit length of the smaller value.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    OP_MUL    = 2'b00,
    OP_MULH   = 2'b01,
    OP_MULHSU = 2'b10,
    OP_MULHU  = 2'b11
  } mul_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CALC = 2'b01,
    ST_FIN  = 2'b10
  } mul_st_e;
endpackage

// File: rtl/smul_swap.sv
module smul_swap
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  mul_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   a_o,
  output logic [W-1:0]   b_o
);
  logic commute;
  logic do_swap;

  // only where both operands share a signedness
  assign commute = (op_i == OP_MUL) || (op_i == OP_MULHU);
  assign do_swap = commute && (b_i > a_i);
  assign a_o     = do_swap ? b_i : a_i;
  assign b_o     = do_swap ? a_i : b_i;
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic early_en_i,
  input  logic b_rest_zero_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

  mul_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    step_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        st_d   = ST_CALC;
      end
      ST_CALC: begin
        step_o = 1'b1;
        if (last_o || (early_en_i && b_rest_zero_i)) st_d = ST_FIN;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign last_o = (st_q == ST_CALC) && (cnt_q == LAST_CNT);
  assign done_o = (st_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_o)      cnt_q <= '0;
      else if (step_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_full_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CALC && !last_o && !early_en_i) |=> (st_q == ST_CALC));
endmodule

// File: rtl/smul_dpath.sv
module smul_dpath
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           last_i,
  input  mul_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           early_en_o,
  output logic           b_rest_zero_o,
  output logic [W-1:0]   result_o
);
  localparam int PW = 2 * W;

  mul_op_e        op_q;
  logic [PW-1:0]  a_q;
  logic [W-1:0]   b_q;
  logic [PW-1:0]  acc_q;
  logic           b_sgn_q;
  logic           a_sgn;
  logic [PW-1:0]  addend;

  assign a_sgn  = (op_i == OP_MULH) || (op_i == OP_MULHSU);
  assign addend = b_q[0] ? a_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_MUL;
      a_q     <= '0;
      b_q     <= '0;
      acc_q   <= '0;
      b_sgn_q <= 1'b0;
    end else if (load_i) begin
      op_q    <= op_i;
      a_q     <= {{W{a_sgn & a_i[W-1]}}, a_i};
      b_q     <= b_i;
      acc_q   <= '0;
      b_sgn_q <= (op_i == OP_MULH);
    end else if (step_i) begin
      // sign bit of a signed iterated operand weighs negative
      acc_q <= (last_i && b_sgn_q) ? acc_q - addend : acc_q + addend;
      a_q   <= a_q << 1;
      b_q   <= b_q >> 1;
    end
  end

  assign early_en_o    = (op_q == OP_MUL);
  assign b_rest_zero_o = (b_q[W-1:1] == '0);
  assign result_o      = (op_q == OP_MUL) ? acc_q[W-1:0] : acc_q[PW-1:W];

  p_acc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(acc_q));
endmodule

// File: rtl/smul_top.sv
module smul_top
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  mul_op_e      op;
  logic [W-1:0] a_sw, b_sw;
  logic         load, step, last, early_en, b_rest_zero;

  assign op = mul_op_e'(op_i);

  smul_swap #(.W(W)) u_swap (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .a_o  (a_sw),
    .b_o  (b_sw)
  );

  smul_ctrl #(.W(W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .early_en_i    (early_en),
    .b_rest_zero_i (b_rest_zero),
    .load_o        (load),
    .step_o        (step),
    .last_o        (last),
    .done_o        (done_o)
  );

  smul_dpath #(.W(W)) u_dpath (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (load),
    .step_i        (step),
    .last_i        (last),
    .op_i          (op),
    .a_i           (a_sw),
    .b_i           (b_sw),
    .early_en_o    (early_en),
    .b_rest_zero_o (b_rest_zero),
    .result_o      (result_o)
  );

  p_zero_fast_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && op == OP_MUL && (a_i == '0 || b_i == '0)) |=> ##1 done_o);
endmodule

// File: tb/sim_smul_top.sv
`timescale 1ns/1ps
module sim_smul_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] result_o;
  logic        done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  smul_top u0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .done_o   (done_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [1:0] op, input logic [31:0] a,
                                           input logic [31:0] b);
    logic [63:0] ea, eb;
    ea = (op == 2'b01 || op == 2'b10) ? {{32{a[31]}}, a} : {32'h0, a};
    eb = (op == 2'b01) ? {{32{b[31]}}, b} : {32'h0, b};
    return ea * eb;
  endfunction

  function automatic int ref_lat(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] m;
    int n;
    if (op != 2'b00) return 32;
    m = (b > a) ? a : b;
    n = 0;
    for (int i = 0; i < 32; i++) if (m[i]) n = i + 1;
    return (n == 0) ? 1 : n;
  endfunction

  // issue one op; returns result and edges-to-done
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input int poke_at, output logic [31:0] res, output int lat);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    res = '0;
    for (int c = 1; c <= 40; c++) begin
      if (c == poke_at) begin
        start_i = 1'b1; a_i = 32'h1234_5678; b_i = 32'h0000_0003; op_i = 2'b00;
      end
      @(posedge clk_i);
      #1;
      if (c == poke_at) start_i = 1'b0;
      if (done_o) begin
        lat = c;
        res = result_o;
        break;
      end
    end
  endtask

  task automatic run_case(input string req, input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] b);
    logic [31:0] res;
    int lat;
    logic [63:0] p;
    issue(op, a, b, 0, res, lat);
    p = ref_prod(op, a, b);
    check(req, {32'h0, res}, (op == 2'b00) ? {32'h0, p[31:0]} : {32'h0, p[63:32]});
    check(req, 64'(lat), 64'(ref_lat(op, a, b)));
    @(posedge clk_i); #1;
    check("R6 pulse", {63'h0, done_o}, 64'h0);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1 check("R8 reset", {63'h0, done_o}, 64'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #1 check("R8 idle", {63'h0, done_o}, 64'h0);
  endtask

  task automatic t_mul;
    run_case("R1 R3", 2'b00, 32'd7, 32'd6);
    run_case("R1 R3", 2'b00, 32'hDEAD_BEEF, 32'h0000_0100);
    run_case("R1 R3", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_case("R1 R3", 2'b00, 32'h8000_0001, 32'h7FFF_FFFF);
  endtask

  task automatic t_zero;
    run_case("R9 zero b", 2'b00, 32'hABCD_0123, 32'h0);
    run_case("R9 zero a", 2'b00, 32'h0, 32'hFFFF_FFFF);
    run_case("R9 ones", 2'b00, 32'h1, 32'h1);
  endtask

  task automatic t_swap;
    run_case("R5 order1", 2'b00, 32'h0000_0005, 32'h0012_3456);
    run_case("R5 order2", 2'b00, 32'h0012_3456, 32'h0000_0005);
    run_case("R5 hu1", 2'b11, 32'hF000_0003, 32'h0000_0009);
    run_case("R5 hu2", 2'b11, 32'h0000_0009, 32'hF000_0003);
  endtask

  task automatic t_high;
    run_case("R2 R4 mulh", 2'b01, 32'hFFFF_FFFE, 32'h0000_0003);
    run_case("R2 R4 mulh", 2'b01, 32'h8000_0000, 32'h8000_0000);
    run_case("R2 R4 mulh", 2'b01, 32'h1234_5678, 32'hF000_0001);
    run_case("R2 R4 mulhsu", 2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_case("R2 R4 mulhsu", 2'b10, 32'h7FFF_0000, 32'h8000_0002);
    run_case("R2 R4 mulhu", 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_case("R2 R4 mulhu", 2'b11, 32'h0, 32'h1);
  endtask

  task automatic t_busy;
    logic [31:0] res;
    int lat;
    logic [63:0] p;
    issue(2'b01, 32'h8765_4321, 32'hC000_0007, 4, res, lat);
    p = ref_prod(2'b01, 32'h8765_4321, 32'hC000_0007);
    check("R7 result", {32'h0, res}, {32'h0, p[63:32]});
    check("R7 latency", 64'(lat), 64'd32);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_i); #1;
      check("R7 no extra done", {63'h0, done_o}, 64'h0);
    end
  endtask

  task automatic t_b2b;
    run_case("R6 back1", 2'b00, 32'd3, 32'd3);
    run_case("R6 back2", 2'b10, 32'h8000_0000, 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_mul();
    t_zero();
    t_swap();
    t_high();
    t_busy();
    t_b2b();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule